// File: doc/BRIEF.md
# RAM Window Address Decoder with I/O Hole

This block decodes a 32-bit physical address against one RAM device whose size is given in megabytes at run time. The whole RAM is reachable through a high window. Two low aliases sit on either side of a fixed I/O hole. The first starts at address zero. The second starts at 512 MB, uses an identity offset, and exists only for large RAM configurations. For every address the decoder reports which RAM window hit and the offset inside the RAM device.

It also reports when the address lies in the I/O hole. Addresses in the low 512 MB that hit neither RAM nor the hole are reported as an empty-slot access. The bus should complete such an access silently: a read returns zero and a write is dropped. The block is purely combinational and sits between the bus address stage and the RAM and I/O selectors.

Top module: `ram_alias_decoder`

## Requirements
- R1: When `0x8000_0000 <= addr` and `addr - 0x8000_0000 < ram_mb*2^20`, then `ram_win == 3'b001` and `ram_off` equals `addr - 0x8000_0000`.
- R2: When `addr < min(ram_mb, 256)*2^20`, then `ram_win == 3'b010` and `ram_off` equals `addr`.
- R3: When `ram_mb > 512` and `0x2000_0000 <= addr < ram_mb*2^20`, then `ram_win == 3'b100` and `ram_off` equals `addr`. With `ram_mb <= 512`, no address at or above `0x2000_0000` and below `0x8000_0000` hits RAM.
- R4: Addresses from `0x1000_0000` through `0x1FFF_FFFF` raise `io_hole` and never raise any `ram_win` bit.
- R5: An address below `0x2000_0000` that hits no RAM window and is not in the hole raises `empty_hit`. The bus completes it with zero read data and a discarded write.
- R6: At most one bit of `ram_win` is set. At most one of `ram_hit`, `io_hole` and `empty_hit` is set. `ram_hit` is the OR of `ram_win`.
- R7: When `ram_mb > 2048`, `cfg_err` is set and no RAM window hits. The hole and empty-slot decoding still apply.
- R8: When no RAM window hits, `ram_off` is zero. An address that hits nothing raises none of the three hit flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 32 | Physical byte address |
| ram_mb | input | 12 | Configured RAM size in megabytes |
| ram_hit | output | 1 | Some RAM window hit |
| ram_win | output | 3 | One-hot window: bit0 high, bit1 low alias, bit2 post-hole alias |
| ram_off | output | 32 | Byte offset inside the RAM device |
| io_hole | output | 1 | Address lies in the I/O hole |
| empty_hit | output | 1 | Unmapped low address, completes silently |
| cfg_err | output | 1 | Configured size above the supported maximum |

## Verification
The checker assumes that `addr` and `ram_mb` are settled, known values whenever its immediate checks evaluate. It also assumes that a size above the maximum is a configuration fault rather than a live mode. The stimulus changes the inputs only on the falling clock edge and samples half a period later, so every check sees a stable combinational result. The vector table and the sweep both include out-of-range sizes, so the fault case is exercised without relying on it in normal decoding.

// File: rtl/ram_alias_pkg.sv
package ram_alias_pkg;
  localparam int unsigned AW       = 32;
  localparam int unsigned SZW      = 12;
  localparam int unsigned MB_SHIFT = 20;
  localparam int unsigned NWIN     = 3;
  localparam int unsigned WIN_HIGH = 0;
  localparam int unsigned WIN_LOW  = 1;
  localparam int unsigned WIN_POST = 2;
  typedef logic [AW-1:0] addr_t;
endpackage

// File: rtl/ram_alias_len.sv
module ram_alias_len
  import ram_alias_pkg::*;
#(
  parameter int unsigned MAX_MB   = 2048,
  parameter int unsigned LOW_MB   = 256,
  parameter int unsigned SPLIT_MB = 512
) (
  input  logic [SZW-1:0] ram_mb,
  output logic           cfg_err,
  output addr_t          len_high,
  output addr_t          len_low,
  output addr_t          len_post
);
  localparam logic [SZW-1:0] MAX_V   = SZW'(MAX_MB);
  localparam logic [SZW-1:0] LOW_V   = SZW'(LOW_MB);
  localparam logic [SZW-1:0] SPLIT_V = SZW'(SPLIT_MB);

  logic [SZW-1:0] low_mb;
  logic [SZW-1:0] post_mb;

  always_comb begin
    cfg_err = (ram_mb > MAX_V);
    low_mb  = (ram_mb < LOW_V) ? ram_mb : LOW_V;
    post_mb = (ram_mb > SPLIT_V) ? (ram_mb - SPLIT_V) : '0;
    if (cfg_err) begin
      len_high = '0;
      len_low  = '0;
      len_post = '0;
    end else begin
      len_high = addr_t'(ram_mb)  << MB_SHIFT;
      len_low  = addr_t'(low_mb)  << MB_SHIFT;
      len_post = addr_t'(post_mb) << MB_SHIFT;
    end
  end
endmodule

// File: rtl/ram_alias_window.sv
module ram_alias_window
  import ram_alias_pkg::*;
#(
  parameter logic [31:0] BASE     = 32'h0,
  parameter logic [31:0] OFF_BASE = 32'h0
) (
  input  addr_t addr,
  input  addr_t len,
  output logic  hit,
  output addr_t off
);
  addr_t rel;

  always_comb begin
    rel = addr - addr_t'(BASE);
    hit = (addr >= addr_t'(BASE)) && (rel < len);
    off = rel + addr_t'(OFF_BASE);
  end
endmodule

// File: rtl/ram_alias_decoder.sv
module ram_alias_decoder
  import ram_alias_pkg::*;
#(
  parameter int unsigned MAX_MB     = 2048,
  parameter int unsigned LOW_MB     = 256,
  parameter int unsigned SPLIT_MB   = 512,
  parameter logic [31:0] HIGH_BASE  = 32'h8000_0000,
  parameter logic [31:0] HOLE_START = 32'h1000_0000,
  parameter logic [31:0] HOLE_END   = 32'h2000_0000,
  parameter logic [31:0] EMPTY_TOP  = 32'h2000_0000
) (
  input  logic [31:0] addr,
  input  logic [11:0] ram_mb,
  output logic        ram_hit,
  output logic [2:0]  ram_win,
  output logic [31:0] ram_off,
  output logic        io_hole,
  output logic        empty_hit,
  output logic        cfg_err
);
  localparam logic [31:0] SPLIT_BASE = 32'(SPLIT_MB) << MB_SHIFT;

  addr_t len_v [NWIN];
  addr_t off_v [NWIN];
  logic  hit_v [NWIN];

  ram_alias_len #(
    .MAX_MB  (MAX_MB),
    .LOW_MB  (LOW_MB),
    .SPLIT_MB(SPLIT_MB)
  ) u_len (
    .ram_mb  (ram_mb),
    .cfg_err (cfg_err),
    .len_high(len_v[WIN_HIGH]),
    .len_low (len_v[WIN_LOW]),
    .len_post(len_v[WIN_POST])
  );

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    localparam logic [31:0] W_BASE = (gi == WIN_HIGH) ? HIGH_BASE  :
                                     (gi == WIN_POST) ? SPLIT_BASE : 32'h0;
    localparam logic [31:0] W_OFF  = (gi == WIN_POST) ? SPLIT_BASE : 32'h0;
    ram_alias_window #(
      .BASE    (W_BASE),
      .OFF_BASE(W_OFF)
    ) u_win (
      .addr(addr),
      .len (len_v[gi]),
      .hit (hit_v[gi]),
      .off (off_v[gi])
    );
  end

  logic in_hole;
  logic [2:0] win_sel;
  addr_t off_sel;

  // Fixed priority: high window, then low alias, then post-hole alias.
  always_comb begin
    in_hole = (addr >= addr_t'(HOLE_START)) && (addr < addr_t'(HOLE_END));
    win_sel = '0;
    off_sel = '0;
    if (!in_hole) begin
      for (int i = 0; i < NWIN; i++) begin
        if (hit_v[i] && (win_sel == '0)) begin
          win_sel[i] = 1'b1;
          off_sel    = off_v[i];
        end
      end
    end
  end

  always_comb begin
    ram_win   = win_sel;
    ram_hit   = |win_sel;
    ram_off   = off_sel;
    io_hole   = in_hole;
    empty_hit = (addr < addr_t'(EMPTY_TOP)) && !in_hole && !(|win_sel);
  end
endmodule

module ram_alias_decoder_chk (
  input logic [31:0] addr,
  input logic [11:0] ram_mb,
  input logic        ram_hit,
  input logic [2:0]  ram_win,
  input logic [31:0] ram_off,
  input logic        io_hole,
  input logic        empty_hit,
  input logic        cfg_err
);
  always_comb begin
    // R6
    one_window_chk: assert ($onehot0(ram_win));
    // R6
    one_flag_chk: assert ($countones({ram_hit, io_hole, empty_hit}) <= 1);
    // R4
    hole_no_ram_chk: assert (!(io_hole && ram_hit));
    // R7
    cfg_no_ram_chk: assert (!(cfg_err && ram_hit));
    // R1
    high_upper_chk: assert (!ram_win[0] || (addr[31] && ram_off[31] == 1'b0));
    // R2
    low_ident_chk: assert (!ram_win[1] || (ram_off == addr && addr < 32'h1000_0000));
    // R3
    post_ident_chk: assert (!ram_win[2] || (ram_off == addr && ram_mb > 12'd512));
    // R5
    empty_low_chk: assert (!empty_hit || addr < 32'h2000_0000);
    // R8
    idle_off_chk: assert (ram_hit || ram_off == 32'h0);
  end
endmodule

bind ram_alias_decoder ram_alias_decoder_chk u_chk (
  .addr     (addr),
  .ram_mb   (ram_mb),
  .ram_hit  (ram_hit),
  .ram_win  (ram_win),
  .ram_off  (ram_off),
  .io_hole  (io_hole),
  .empty_hit(empty_hit),
  .cfg_err  (cfg_err)
);

// File: tb/tb_ram_alias_decoder.sv
module tb_ram_alias_decoder;
  logic clk;
  logic rst_n;
  logic [31:0] addr;
  logic [11:0] ram_mb;
  logic        ram_hit;
  logic [2:0]  ram_win;
  logic [31:0] ram_off;
  logic        io_hole;
  logic        empty_hit;
  logic        cfg_err;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  ram_alias_decoder dut (
    .addr(addr), .ram_mb(ram_mb), .ram_hit(ram_hit), .ram_win(ram_win),
    .ram_off(ram_off), .io_hole(io_hole), .empty_hit(empty_hit), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: {req[3:0], addr[31:0], mb[11:0], win[2:0], hole, empty, err, off[31:0]}
  localparam int NV = 21;
  localparam logic [85:0] VEC [NV] = '{
    {4'd1, 32'h8000_0000, 12'h100, 3'b001, 3'b000, 32'h0000_0000}, // R1 base
    {4'd1, 32'h8FFF_FFFF, 12'h100, 3'b001, 3'b000, 32'h0FFF_FFFF}, // R1 top
    {4'd8, 32'h9000_0000, 12'h100, 3'b000, 3'b000, 32'h0000_0000}, // R8 past end
    {4'd1, 32'hFFFF_FFFF, 12'h800, 3'b001, 3'b000, 32'h7FFF_FFFF}, // R1 max size
    {4'd2, 32'h0000_1234, 12'h100, 3'b010, 3'b000, 32'h0000_1234}, // R2
    {4'd2, 32'h07FF_FFFF, 12'h080, 3'b010, 3'b000, 32'h07FF_FFFF}, // R2 small RAM edge
    {4'd5, 32'h0800_0000, 12'h080, 3'b000, 3'b010, 32'h0000_0000}, // R5 past small RAM
    {4'd2, 32'h0FFF_FFFF, 12'h800, 3'b010, 3'b000, 32'h0FFF_FFFF}, // R2 capped at 256MB
    {4'd4, 32'h1000_0000, 12'h800, 3'b000, 3'b100, 32'h0000_0000}, // R4 hole start
    {4'd4, 32'h1FFF_FFFF, 12'h400, 3'b000, 3'b100, 32'h0000_0000}, // R4 hole end
    {4'd3, 32'h2000_0000, 12'h400, 3'b100, 3'b000, 32'h2000_0000}, // R3 post base
    {4'd3, 32'h3FFF_FFFF, 12'h400, 3'b100, 3'b000, 32'h3FFF_FFFF}, // R3 post top
    {4'd8, 32'h4000_0000, 12'h400, 3'b000, 3'b000, 32'h0000_0000}, // R8 past post
    {4'd3, 32'h2000_0000, 12'h200, 3'b000, 3'b000, 32'h0000_0000}, // R3 no alias at 512
    {4'd3, 32'h200F_FFFF, 12'h201, 3'b100, 3'b000, 32'h200F_FFFF}, // R3 513MB last byte
    {4'd3, 32'h2010_0000, 12'h201, 3'b000, 3'b000, 32'h0000_0000}, // R3 513MB past end
    {4'd3, 32'h7FFF_FFFF, 12'h800, 3'b100, 3'b000, 32'h7FFF_FFFF}, // R3 max size
    {4'd7, 32'h8000_0000, 12'h801, 3'b000, 3'b001, 32'h0000_0000}, // R7 high blocked
    {4'd7, 32'h0000_0000, 12'h801, 3'b000, 3'b011, 32'h0000_0000}, // R7 empty remains
    {4'd7, 32'h1800_0000, 12'hFFF, 3'b000, 3'b101, 32'h0000_0000}, // R7 hole remains
    {4'd5, 32'h0000_0000, 12'h000, 3'b000, 3'b010, 32'h0000_0000}  // R5 zero RAM
  };

  task automatic check(input int req, input logic [37:0] act, input logic [37:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d addr=%h mb=%0d actual=%h expected=%h", req, addr, ram_mb, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [11:0] m);
    @(negedge clk);
    addr = a;
    ram_mb = m;
    @(posedge clk);
  endtask

  function automatic logic [37:0] model(input logic [31:0] a, input logic [11:0] m);
    logic [32:0] sz;
    logic [2:0] w;
    logic [31:0] o;
    logic hole, emp, err;
    sz = {1'b0, 20'h0, m} << 20;
    err = (m > 12'd2048);
    hole = (a >= 32'h1000_0000) && (a < 32'h2000_0000);
    w = 3'b000;
    o = 32'h0;
    if (!err && !hole) begin
      if (a[31] && {1'b0, (a - 32'h8000_0000)} < sz) begin
        w = 3'b001; o = a - 32'h8000_0000;
      end else if ({1'b0, a} < sz && a < 32'h1000_0000) begin
        w = 3'b010; o = a;
      end else if (m > 12'd512 && a >= 32'h2000_0000 && {1'b0, a} < sz) begin
        w = 3'b100; o = a;
      end
    end
    emp = (a < 32'h2000_0000) && !hole && (w == 3'b000);
    return {w, hole, emp, err, o};
  endfunction

  initial begin
    rst_n = 1'b0;
    addr = '0;
    ram_mb = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R5 reset state: zero address, zero size
    check(5, {ram_win, io_hole, empty_hit, cfg_err, ram_off}, {3'b000, 3'b010, 32'h0});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][81:50], VEC[i][49:38]);
      check(int'(VEC[i][85:82]), {ram_win, io_hole, empty_hit, cfg_err, ram_off}, VEC[i][37:0]);
    end

    // R6 sweep: exclusivity and window match against model
    for (int s = 0; s < 5; s++) begin
      for (int k = 0; k < 32; k++) begin
        logic [11:0] m;
        logic [31:0] a;
        m = (s == 0) ? 12'd64 : (s == 1) ? 12'd300 : (s == 2) ? 12'd1536 :
            (s == 3) ? 12'd2048 : 12'd3000;
        a = (32'(k) << 27) + 32'h0013_5790;
        apply(a, m);
        check(6, {ram_win, io_hole, empty_hit, cfg_err, ram_off}, model(a, m));
        check(6, {35'h0, ram_hit, 1'b0, ($countones({ram_hit, io_hole, empty_hit}) <= 1)},
                 {35'h0, |model(a, m)[37:35], 1'b0, 1'b1});
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule